// File: doc/BRIEF.md
# CSR Read-Modify-Write Instruction Executor

This block executes the six control-register access instructions of a 32-bit RISC-V core. It accepts one instruction word per cycle, marked by a valid strobe. In the same cycle it decodes the word, places the source register index on `rs1_idx` and takes the register value back on `rs1_val`. It then drives read and write strobes, a 12-bit register address and write data toward the control-register bank.

An internal bank of scratch control registers answers these accesses, so the unit can be tested on its own. The bank state changes at the clock edge that ends the issue cycle. In the cycle after that edge the unit presents the previous register value for write-back to the integer register file, the next program counter, and a one-cycle illegal-instruction flag.

Three operations are supported: swap, bit-set and bit-clear. Each comes in a register-source form and a 5-bit immediate form. Every form has its own rule for dropping the read or the write side effect, and those rules matter for registers whose reads or writes have side effects.

Top module: `csr_exec_unit`

## Requirements
- R1: A word is accepted only when bits [6:0] equal 7'h73 and bits [14:12] (the op field) are 1, 2 or 3 (swap, set, clear, with a register source) or 5, 6 or 7 (the same three, with an immediate). Any other word with `instr_valid` high produces no strobe and no write-back, and raises `illegal` for exactly one cycle in the following cycle.
- R2: The destination index is taken from bits [11:7], the source index or immediate from bits [19:15], and the register address from bits [31:20]. `csr_addr` shows bits [31:20] during the issue cycle. The immediate is zero-extended to 32 bits.
- R3: Register swap (op 1) with destination 0 asserts `csr_we` with data `rs1_val` and does not assert `csr_re`. With a nonzero destination it asserts both strobes and returns the old value.
- R4: Register set (op 2) and register clear (op 3) always assert `csr_re`. They assert `csr_we` only when the source index is nonzero, even when the source value is zero, with data old|value for set and old&~value for clear.
- R5: Immediate set (op 6) and immediate clear (op 7) always assert `csr_re`. They assert `csr_we` only when the immediate is nonzero, with data old|imm or old&~imm.
- R6: Immediate swap (op 5) always asserts both `csr_re` and `csr_we`, with the zero-extended immediate as data, whatever the destination index.
- R7: In the cycle after an accepted instruction with a nonzero destination, `rd_we` is high for one cycle, `rd_idx` is the destination index and `rd_wdata` is the register value from before the instruction. `rd_we` is never high with `rd_idx` equal to 0.
- R8: In the cycle after any valid instruction, `next_pc` equals the `pc` presented with it plus 4, modulo 2^32.
- R9: The bank holds four 32-bit registers at addresses 0x340 to 0x343, all cleared by reset. A write takes effect at the issue edge and is visible to the next instruction. An accepted word whose address lies outside this range is flagged as illegal, as in R1, and changes no register.
- R10: `rs1_idx` equals bits [19:15] for an accepted-format register-source word and is 0 otherwise.
- R11: While reset is asserted, `rd_we`, `illegal` and `next_pc` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| pc | input | 32 | Program counter of the instruction |
| rs1_idx | output | 5 | Source register index toward the register file |
| rs1_val | input | 32 | Source register value, returned combinationally |
| csr_re | output | 1 | Control-register read strobe |
| csr_we | output | 1 | Control-register write strobe |
| csr_addr | output | 12 | Control-register address |
| csr_wdata | output | 32 | Control-register write data |
| rd_we | output | 1 | Write-back enable, one cycle after issue |
| rd_idx | output | 5 | Write-back destination index |
| rd_wdata | output | 32 | Write-back data (previous register value) |
| next_pc | output | 32 | Next program counter |
| illegal | output | 1 | Illegal-instruction pulse |

## Verification
The bench sweeps every op-field value, including the unused values 0 and 4, across addresses just below the bank, inside it and just above it. Each combination is tried with destination indices 0 and nonzero and with source indices 0, one nonzero index whose register holds zero, and indices holding dense bit patterns. The zero-index versus zero-value pair separates a design that gates the set or clear write on the index from one that gates it on the value. The destination-0 cases separate register swap, which drops its read, from immediate swap, which keeps it. Program counters run across the 32-bit wrap point, and because the bank state carries over the whole sweep, each result depends on all earlier writes.

// File: rtl/csr_exec_pkg.sv
package csr_exec_pkg;

   localparam int REG_IDX_W  = 5;
   localparam int CSR_ADDR_W = 12;
   localparam int ILEN       = 32;

   typedef enum logic [1:0] {
      CSR_OP_NONE = 2'd0,
      CSR_OP_SWAP = 2'd1,
      CSR_OP_SET  = 2'd2,
      CSR_OP_CLR  = 2'd3
   } csr_op_e;

   typedef struct packed {
      logic                  match;
      csr_op_e               op;
      logic                  imm_form;
      logic [REG_IDX_W-1:0]  dst;
      logic [REG_IDX_W-1:0]  src;
      logic [CSR_ADDR_W-1:0] addr;
   } csr_dec_t;

endpackage

// File: rtl/csr_exec_decode.sv
module csr_exec_decode
   import csr_exec_pkg::*;
(
   input  logic [ILEN-1:0] instr,
   output csr_dec_t        dec
);

   localparam logic [6:0] SYS_OPCODE = 7'b1110011;

   logic [2:0] op_field;
   logic       opc_ok;

   assign op_field = instr[14:12];
   assign opc_ok   = (instr[6:0] == SYS_OPCODE);

   always_comb begin
      dec.match    = opc_ok && (op_field[1:0] != 2'b00);
      dec.imm_form = op_field[2];
      dec.op       = dec.match ? csr_op_e'(op_field[1:0]) : CSR_OP_NONE;
      dec.dst      = instr[11:7];
      dec.src      = instr[19:15];
      dec.addr     = instr[31:20];
   end

endmodule

// File: rtl/csr_scratch_bank.sv
module csr_scratch_bank #(
   parameter int                XLEN      = 32,
   parameter int                ADDR_W    = 12,
   parameter int                NUM_REGS  = 4,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h340
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [XLEN-1:0]   wdata,
   output logic              hit,
   output logic [XLEN-1:0]   rdata
);

   logic [NUM_REGS-1:0] sel;
   logic [XLEN-1:0]     store [NUM_REGS];

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
      localparam logic [ADDR_W-1:0] MY_ADDR = BASE_ADDR + ADDR_W'(g);
      assign sel[g] = (addr == MY_ADDR);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            store[g] <= '0;
         end else if (we && sel[g]) begin
            store[g] <= wdata;
         end
      end
   end

   assign hit = |sel;

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         rdata = rdata | (store[i] & {XLEN{sel[i]}});
      end
   end

endmodule

// File: rtl/csr_exec_datapath.sv
module csr_exec_datapath
   import csr_exec_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  csr_dec_t        dec,
   input  logic [XLEN-1:0] rs1_val,
   input  logic [XLEN-1:0] old_val,
   output logic            want_rd,
   output logic            want_wr,
   output logic [XLEN-1:0] new_val
);

   logic [XLEN-1:0] operand;
   logic            src_nz;
   logic            dst_nz;

   assign operand = dec.imm_form ? XLEN'(dec.src) : rs1_val;
   assign src_nz  = (dec.src != '0);
   assign dst_nz  = (dec.dst != '0);

   always_comb begin
      want_rd = 1'b0;
      want_wr = 1'b0;
      new_val = operand;
      unique case (dec.op)
         CSR_OP_SWAP: begin
            want_rd = dec.imm_form | dst_nz;
            want_wr = 1'b1;
            new_val = operand;
         end
         CSR_OP_SET: begin
            want_rd = 1'b1;
            want_wr = src_nz;
            new_val = old_val | operand;
         end
         CSR_OP_CLR: begin
            want_rd = 1'b1;
            want_wr = src_nz;
            new_val = old_val & ~operand;
         end
         default: begin
            want_rd = 1'b0;
            want_wr = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/csr_exec_unit.sv
module csr_exec_unit
   import csr_exec_pkg::*;
#(
   parameter int                    XLEN        = 32,
   parameter int                    NUM_SCRATCH = 4,
   parameter logic [CSR_ADDR_W-1:0] SCR_BASE    = 12'h340
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  instr_valid,
   input  logic [ILEN-1:0]       instr,
   input  logic [XLEN-1:0]       pc,
   output logic [REG_IDX_W-1:0]  rs1_idx,
   input  logic [XLEN-1:0]       rs1_val,
   output logic                  csr_re,
   output logic                  csr_we,
   output logic [CSR_ADDR_W-1:0] csr_addr,
   output logic [XLEN-1:0]       csr_wdata,
   output logic                  rd_we,
   output logic [REG_IDX_W-1:0]  rd_idx,
   output logic [XLEN-1:0]       rd_wdata,
   output logic [XLEN-1:0]       next_pc,
   output logic                  illegal
);

   localparam int              BANK_END = int'(SCR_BASE) + NUM_SCRATCH;
   localparam logic [XLEN-1:0] PC_STEP  = XLEN'(4);

   if (XLEN < 32) begin : g_bad_xlen
      $error("csr_exec_unit: XLEN must be at least 32");
   end
   if (NUM_SCRATCH < 1) begin : g_bad_depth
      $error("csr_exec_unit: NUM_SCRATCH must be at least 1");
   end
   if (BANK_END > (1 << CSR_ADDR_W)) begin : g_bad_range
      $error("csr_exec_unit: scratch bank exceeds the address space");
   end

   csr_dec_t        dec;
   logic            bank_hit;
   logic [XLEN-1:0] bank_rdata;
   logic            want_rd;
   logic            want_wr;
   logic [XLEN-1:0] new_val;
   logic            accept;

   csr_exec_decode u_dec (
      .instr (instr),
      .dec   (dec)
   );

   csr_exec_datapath #(.XLEN(XLEN)) u_dp (
      .dec     (dec),
      .rs1_val (rs1_val),
      .old_val (bank_rdata),
      .want_rd (want_rd),
      .want_wr (want_wr),
      .new_val (new_val)
   );

   assign accept    = instr_valid && dec.match && bank_hit;
   assign rs1_idx   = (dec.match && !dec.imm_form) ? dec.src : '0;
   assign csr_addr  = dec.addr;
   assign csr_re    = accept && want_rd;
   assign csr_we    = accept && want_wr;
   assign csr_wdata = new_val;

   csr_scratch_bank #(
      .XLEN      (XLEN),
      .ADDR_W    (CSR_ADDR_W),
      .NUM_REGS  (NUM_SCRATCH),
      .BASE_ADDR (SCR_BASE)
   ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (dec.addr),
      .we    (csr_we),
      .wdata (new_val),
      .hit   (bank_hit),
      .rdata (bank_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_we    <= 1'b0;
         rd_idx   <= '0;
         rd_wdata <= '0;
         illegal  <= 1'b0;
         next_pc  <= '0;
      end else begin
         rd_we   <= accept && (dec.dst != '0);
         illegal <= instr_valid && !accept;
         if (accept) begin
            rd_idx   <= dec.dst;
            rd_wdata <= bank_rdata;
         end
         if (instr_valid) begin
            next_pc <= pc + PC_STEP;
         end
      end
   end

endmodule

// File: rtl/csr_exec_checker.sv
module csr_exec_checker #(
   parameter int          XLEN        = 32,
   parameter int          NUM_SCRATCH = 4,
   parameter logic [11:0] SCR_BASE    = 12'h340
) (
   input logic            clk,
   input logic            rst_n,
   input logic            instr_valid,
   input logic [31:0]     instr,
   input logic [XLEN-1:0] pc,
   input logic            csr_re,
   input logic            csr_we,
   input logic [11:0]     csr_addr,
   input logic            rd_we,
   input logic [4:0]      rd_idx,
   input logic [XLEN-1:0] next_pc,
   input logic            illegal
);

   localparam logic [XLEN-1:0] STEP   = XLEN'(4);
   localparam int              TOP_EX = int'(SCR_BASE) + NUM_SCRATCH;

   logic in_bank;
   logic sys_word;
   logic valid_sys;

   assign in_bank   = (int'(csr_addr) >= int'(SCR_BASE)) && (int'(csr_addr) < TOP_EX);
   assign sys_word  = (instr[6:0] == 7'h73);
   assign valid_sys = instr_valid && sys_word && in_bank;

   assert_access_in_bank_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_re || csr_we) |-> in_bank);

   assert_x0_not_written_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_we |-> (rd_idx != 5'd0));

   assert_illegal_no_writeback_R1: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> !rd_we);

   assert_pc_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      instr_valid |=> (next_pc == $past(pc) + STEP));

   assert_imm_swap_reads_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_sys && instr[14:12] == 3'd5) |-> (csr_re && csr_we));

   assert_reg_swap_x0_no_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_sys && instr[14:12] == 3'd1 && instr[11:7] == 5'd0) |-> (!csr_re && csr_we));

   assert_idle_no_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid |-> !(csr_re || csr_we));

endmodule

bind csr_exec_unit csr_exec_checker #(
   .XLEN        (XLEN),
   .NUM_SCRATCH (NUM_SCRATCH),
   .SCR_BASE    (SCR_BASE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .instr_valid (instr_valid),
   .instr       (instr),
   .pc          (pc),
   .csr_re      (csr_re),
   .csr_we      (csr_we),
   .csr_addr    (csr_addr),
   .rd_we       (rd_we),
   .rd_idx      (rd_idx),
   .next_pc     (next_pc),
   .illegal     (illegal)
);

// File: tb/test_csr_exec_unit.sv
`timescale 1ns/1ps
module test_csr_exec_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [31:0] instr = '0;
   logic [31:0] pc = '0;
   logic [4:0]  rs1_idx;
   logic [31:0] rs1_val;
   logic        csr_re, csr_we;
   logic [11:0] csr_addr;
   logic [31:0] csr_wdata;
   logic        rd_we;
   logic [4:0]  rd_idx;
   logic [31:0] rd_wdata;
   logic [31:0] next_pc;
   logic        illegal;

   int checks = 0;
   int fails  = 0;

   logic [31:0] rf [32];
   logic [31:0] mbank [4];

   always #2.5 clk = ~clk;

   assign rs1_val = rf[rs1_idx];

   csr_exec_unit i_csr_exec_unit (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr), .pc(pc),
      .rs1_idx(rs1_idx), .rs1_val(rs1_val), .csr_re(csr_re), .csr_we(csr_we),
      .csr_addr(csr_addr), .csr_wdata(csr_wdata), .rd_we(rd_we), .rd_idx(rd_idx),
      .rd_wdata(rd_wdata), .next_pc(next_pc), .illegal(illegal)
   );

   task automatic chk(input string tag, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic issue(input logic [31:0] w, input logic [31:0] p);
      logic [2:0]  f3;
      logic [11:0] a;
      logic [4:0]  rdf, sf;
      logic        fmt_ok, legal, imm, e_re, e_we;
      logic [31:0] v, old, nv;
      string       tag;
      f3     = w[14:12];
      a      = w[31:20];
      rdf    = w[11:7];
      sf     = w[19:15];
      imm    = f3[2];
      fmt_ok = (w[6:0] == 7'h73) && (f3[1:0] != 2'b00);
      legal  = fmt_ok && (a >= 12'h340) && (a < 12'h344);
      v      = imm ? {27'b0, sf} : rf[sf];
      old    = legal ? mbank[a[1:0]] : 32'h0;
      e_re = 1'b0; e_we = 1'b0; nv = 32'h0;
      tag = "R1";
      case (f3[1:0])
         2'd1: begin e_re = imm | (rdf != 0); e_we = 1'b1; nv = v;
                     tag = imm ? "R6" : "R3"; end
         2'd2: begin e_re = 1'b1; e_we = (sf != 0); nv = old | v;
                     tag = imm ? "R5" : "R4"; end
         2'd3: begin e_re = 1'b1; e_we = (sf != 0); nv = old & ~v;
                     tag = imm ? "R5" : "R4"; end
         default: ;
      endcase
      if (!legal) begin
         e_re = 1'b0; e_we = 1'b0;
         tag = fmt_ok ? "R9" : "R1";
      end
      @(negedge clk);
      instr = w; pc = p; instr_valid = 1'b1;
      #1;
      chk(tag, "csr_re", {31'b0, csr_re}, {31'b0, e_re});
      chk(tag, "csr_we", {31'b0, csr_we}, {31'b0, e_we});
      if (e_we) chk(tag, "csr_wdata", csr_wdata, nv);
      if (legal) chk("R2", "csr_addr", {20'b0, csr_addr}, {20'b0, a});
      chk("R10", "rs1_idx", {27'b0, rs1_idx}, (fmt_ok && !imm) ? {27'b0, sf} : 32'h0);
      @(negedge clk);
      instr_valid = 1'b0;
      chk("R7", "rd_we", {31'b0, rd_we}, {31'b0, legal && (rdf != 0)});
      if (legal && rdf != 0) begin
         chk("R2", "rd_idx", {27'b0, rd_idx}, {27'b0, rdf});
         chk("R7", "rd_wdata", rd_wdata, old);
      end
      chk(legal ? "R9" : "R1", "illegal", {31'b0, illegal}, {31'b0, !legal});
      chk("R8", "next_pc", next_pc, p + 32'd4);
      if (e_we) mbank[a[1:0]] = nv;
   endtask

   initial begin
      #(200000 * 5.0);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] cur_pc;
      logic [11:0] addrs [6];
      logic [4:0]  srcs [4];
      for (int i = 0; i < 32; i++) rf[i] = 32'(i) * 32'h9E37_79B1;
      rf[0] = 32'h0;
      rf[5] = 32'h0;
      for (int i = 0; i < 4; i++) mbank[i] = 32'h0;
      addrs[0] = 12'h33F; addrs[1] = 12'h340; addrs[2] = 12'h341;
      addrs[3] = 12'h342; addrs[4] = 12'h343; addrs[5] = 12'h344;
      srcs[0] = 5'd0; srcs[1] = 5'd5; srcs[2] = 5'd7; srcs[3] = 5'd19;
      cur_pc = 32'hFFFF_FF00;

      repeat (4) @(negedge clk);
      // R11: reset values
      chk("R11", "rd_we in reset", {31'b0, rd_we}, 32'h0);
      chk("R11", "illegal in reset", {31'b0, illegal}, 32'h0);
      chk("R11", "next_pc in reset", next_pc, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R9: reset-cleared bank read through immediate set with zero immediate
      for (int k = 0; k < 4; k++) begin
         issue({12'h340 + 12'(k), 5'd0, 3'd6, 5'd1, 7'h73}, cur_pc);
         cur_pc += 4;
      end

      // R1: wrong opcode with a valid-looking op field
      issue({12'h340, 5'd7, 3'd1, 5'd2, 7'h33}, cur_pc);
      cur_pc += 4;

      for (int f = 0; f < 8; f++) begin
         for (int ai = 0; ai < 6; ai++) begin
            for (int d = 0; d < 2; d++) begin
               for (int s = 0; s < 4; s++) begin
                  issue({addrs[ai], srcs[s], 3'(f), (d == 0) ? 5'd0 : 5'd3, 7'h73}, cur_pc);
                  cur_pc += 4;
               end
            end
         end
      end

      // R9: final bank contents read back
      for (int k = 0; k < 4; k++) begin
         issue({12'h340 + 12'(k), 5'd0, 3'd2, 5'd9, 7'h73}, cur_pc);
         cur_pc += 4;
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule